// File: doc/BRIEF.md
# Infrared Array Readout Clock Sequencer

This block drives a large infrared focal-plane readout with only two timing lines, a master clock and a frame-start pulse. It also produces the index of every sample, so capture logic further down the chain knows what each sample is. The indices are the position within the current line of an output strip and the row. The block also flags reference pixels and marks the interval in which a row is reset. Each output strip is read in parallel with the others, so one column index serves all outputs. The array splits either into 16 strips of width `ARR_COLS/16` or into 4 strips of width `ARR_COLS/4`.

A frame is requested with a one-cycle `start_i`. The output mode, the reset enable, the reset type, the half-period divider and the reset hold count are captured at that moment and held for the whole frame. The block first raises frame start for one master-clock half period. It then steps one pixel on every edge of the master clock, row by row.

When resets are enabled, the master clock is frozen while the row reset strobe is high. In line-by-line mode the strobe follows every row. In global mode it comes once, after the last row. Each reset interval lasts one master-clock period plus a programmable number of extra system clocks. A one-cycle done pulse closes the frame.

Top module: `rdseq_top`

## Requirements
- R1: While busy, pixels are stepped in raster order: `pix_valid_o` pulses in the first system clock of each pixel half period. `pix_col_o` runs 0..L-1 within a row and `row_idx_o` runs 0..ARR_ROWS-1. L is ARR_COLS/16+6 with `four_out_i`=0 and ARR_COLS/4 with `four_out_i`=1. At most one of frame start, pixel valid, row reset and frame done is high in any cycle.
- R2: A `start_i` sampled high while idle raises `frame_start_o` from the next cycle for exactly `half_div_i`+1 system clocks, with `mclk_o` low.
- R3: Each pixel lasts `half_div_i`+1 system clocks. `mclk_o` is low for even `pix_col_o` and high for odd, so it toggles at the end of every pixel, and it changes at no other time.
- R4: With `four_out_i`=0, `ref_pix_o` is high for line positions 0 and 1 and for the last four positions, and low for the positions between them. With `four_out_i`=1, no in-row position is a reference.
- R5: Every pixel of row 0 and of row ARR_ROWS-1 is flagged with `ref_pix_o`.
- R6: With `reset_en_i`=1 and `reset_global_i`=0, each row is followed by a reset interval. In it, `row_reset_o` is high for 2*(`half_div_i`+1)+`reset_hold_i` system clocks, `row_idx_o` shows the row being reset, and `mclk_o` holds still.
- R7: With `reset_en_i`=1 and `reset_global_i`=1, exactly one reset interval of the same length follows the last row, with `row_idx_o`=ARR_ROWS-1. With `reset_en_i`=0, no reset interval occurs.
- R8: The controls and divider values take effect only when a frame is accepted. Changes to them, and `start_i` pulses during a frame, leave the running frame unchanged.
- R9: `frame_done_o` is high for one cycle right after the last pixel or the final reset interval. The block is idle in the next cycle.
- R10: In reset and when idle, every output is low and `pix_col_o` and `row_idx_o` are zero. Outside a pixel, `pix_col_o` is zero, and `row_idx_o` is zero except during a reset interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame request, sampled while idle |
| four_out_i | input | 1 | 1 selects 4-output mode, 0 selects 16-output mode |
| reset_en_i | input | 1 | Enables row resets in the frame |
| reset_global_i | input | 1 | 1 gives one reset per frame, 0 gives one reset per row |
| half_div_i | input | DIV_W | Master-clock half period minus one, in system clocks |
| reset_hold_i | input | HOLD_W | Extra system clocks that the master clock is frozen during a reset |
| mclk_o | output | 1 | Master clock to the array |
| frame_start_o | output | 1 | Frame-start pulse to the array |
| pix_valid_o | output | 1 | One-cycle strobe at each pixel step |
| pix_col_o | output | COL_W | Position within the line of each output strip |
| row_idx_o | output | ROW_W | Row of the pixel or of the row being reset |
| ref_pix_o | output | 1 | Current pixel is a reference pixel |
| row_reset_o | output | 1 | Row reset interval in progress |
| frame_done_o | output | 1 | One-cycle end-of-frame pulse |
| busy_o | output | 1 | Frame in progress |

## Verification
Every cycle, the assertions check these properties:
- the four phase indications are mutually exclusive;
- the master clock is low under frame start and frozen throughout a reset interval;
- the master clock moves only at the end of a pixel;
- the column and row counters wrap properly;
- the done pulse is followed by idle.

Only the bench's cycle-by-cycle model can show the rest:
- the exact length of each half period and reset interval for a given divider and hold count;
- the placement of reference flags by mode;
- the choice between per-row and single global resets;
- that controls changed mid-frame are ignored.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FSTART = 3'd1,
        ST_PIXEL  = 3'd2,
        ST_RESET  = 3'd3,
        ST_DONE   = 3'd4
    } seq_state_e;

endpackage

// File: rtl/rdseq_timer.sv
// Phase timer: counts system clocks inside the current phase.
module rdseq_timer #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [CW-1:0] limit,
    output logic          hit,
    output logic          at_zero
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = clr ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit     = (cnt_q == limit);
    assign at_zero = (cnt_q == '0);

    AST_TIMER_NO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !clr && !hit |=> cnt_q != '0); // R3

endmodule

// File: rtl/rdseq_raster.sv
// Column and row position counters for the readout raster.
module rdseq_raster #(
    parameter int COL_W    = 8,
    parameter int ROW_W    = 11,
    parameter int ARR_ROWS = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [COL_W-1:0] last_col,
    output logic [COL_W-1:0] col,
    output logic [ROW_W-1:0] row,
    output logic             at_last_col,
    output logic             at_last_row
);

    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ARR_ROWS - 1);

    logic [COL_W-1:0] col_d, col_q;
    logic [ROW_W-1:0] row_d, row_q;

    assign at_last_col = (col_q == last_col);
    assign at_last_row = (row_q == LAST_ROW);

    always_comb begin
        col_d = col_q;
        row_d = row_q;
        if (clr) begin
            col_d = '0;
            row_d = '0;
        end else if (step) begin
            if (at_last_col) begin
                col_d = '0;
                row_d = at_last_row ? '0 : row_q + ROW_W'(1);
            end else begin
                col_d = col_q + COL_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
            row_q <= '0;
        end else begin
            col_q <= col_d;
            row_q <= row_d;
        end
    end

    assign col = col_q;
    assign row = row_q;

    AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr && step && at_last_col |=> col_q == '0); // R1
    AST_ROW_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr && step && at_last_col && !at_last_row |=> row_q == $past(row_q) + ROW_W'(1)); // R1

endmodule

// File: rtl/rdseq_refmap.sv
// Classifies the current raster position as reference or active.
module rdseq_refmap #(
    parameter int COL_W    = 8,
    parameter int ROW_W    = 11,
    parameter int ARR_ROWS = 2048,
    parameter int STRIP16  = 128,
    parameter int PRE_REF  = 2
) (
    input  logic [COL_W-1:0] col,
    input  logic [ROW_W-1:0] row,
    input  logic             four_mode,
    output logic             is_ref
);

    localparam logic [ROW_W-1:0] TOP_ROW   = ROW_W'(ARR_ROWS - 1);
    localparam logic [COL_W-1:0] POST_FROM = COL_W'(PRE_REF + STRIP16);

    logic lead_ref;
    logic edge_row;

    generate
        if (PRE_REF > 0) begin : g_lead
            assign lead_ref = (col < COL_W'(PRE_REF));
        end else begin : g_nolead
            assign lead_ref = 1'b0;
        end
    endgenerate

    assign edge_row = (row == '0) || (row == TOP_ROW);
    assign is_ref   = edge_row || (!four_mode && (lead_ref || (col >= POST_FROM)));

endmodule

// File: rtl/rdseq_top.sv
module rdseq_top #(
    parameter int ARR_ROWS = 2048,
    parameter int ARR_COLS = 2048,
    parameter int PRE_REF  = 2,
    parameter int POST_REF = 4,
    parameter int DIV_W    = 8,
    parameter int HOLD_W   = 12,
    localparam int STRIP16  = ARR_COLS / 16,
    localparam int STRIP4   = ARR_COLS / 4,
    localparam int LINE16   = STRIP16 + PRE_REF + POST_REF,
    localparam int LINE_MAX = (LINE16 > STRIP4) ? LINE16 : STRIP4,
    localparam int COL_W    = $clog2(LINE_MAX),
    localparam int ROW_W    = $clog2(ARR_ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              four_out_i,
    input  logic              reset_en_i,
    input  logic              reset_global_i,
    input  logic [DIV_W-1:0]  half_div_i,
    input  logic [HOLD_W-1:0] reset_hold_i,
    output logic              mclk_o,
    output logic              frame_start_o,
    output logic              pix_valid_o,
    output logic [COL_W-1:0]  pix_col_o,
    output logic [ROW_W-1:0]  row_idx_o,
    output logic              ref_pix_o,
    output logic              row_reset_o,
    output logic              frame_done_o,
    output logic              busy_o
);
    import rdseq_pkg::*;

    // Line lengths must be even so the master clock ends each row low.
    localparam int CW = ((DIV_W > HOLD_W) ? DIV_W : HOLD_W) + 2;
    localparam logic [COL_W-1:0] LAST16 = COL_W'(LINE16 - 1);
    localparam logic [COL_W-1:0] LAST4  = COL_W'(STRIP4 - 1);

    typedef struct packed {
        seq_state_e        st;
        logic              mclk;
        logic              four;
        logic              ren;
        logic              glob;
        logic [DIV_W-1:0]  div;
        logic [HOLD_W-1:0] hold;
    } ctl_t;

    ctl_t q, d;

    logic             tmr_clr, tmr_hit, tmr_zero;
    logic [CW-1:0]    tmr_limit;
    logic             ras_clr, ras_step;
    logic [COL_W-1:0] col, last_col;
    logic [ROW_W-1:0] row;
    logic             at_last_col, at_last_row;
    logic             ref_raw;
    logic             line_rst, glob_rst;

    assign line_rst = q.ren && !q.glob;
    assign glob_rst = q.ren && q.glob;
    assign last_col = q.four ? LAST4 : LAST16;

    // Reset phase spans one master-clock period plus the hold count.
    always_comb begin
        if (q.st == ST_RESET)
            tmr_limit = (CW'(q.div) << 1) + CW'(1) + CW'(q.hold);
        else
            tmr_limit = CW'(q.div);
    end

    rdseq_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .limit   (tmr_limit),
        .hit     (tmr_hit),
        .at_zero (tmr_zero)
    );

    rdseq_raster #(.COL_W(COL_W), .ROW_W(ROW_W), .ARR_ROWS(ARR_ROWS)) u_raster (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (ras_clr),
        .step        (ras_step),
        .last_col    (last_col),
        .col         (col),
        .row         (row),
        .at_last_col (at_last_col),
        .at_last_row (at_last_row)
    );

    rdseq_refmap #(
        .COL_W(COL_W), .ROW_W(ROW_W), .ARR_ROWS(ARR_ROWS),
        .STRIP16(STRIP16), .PRE_REF(PRE_REF)
    ) u_refmap (
        .col       (col),
        .row       (row),
        .four_mode (q.four),
        .is_ref    (ref_raw)
    );

    always_comb begin
        d        = q;
        tmr_clr  = 1'b0;
        ras_clr  = 1'b0;
        ras_step = 1'b0;
        case (q.st)
            ST_IDLE: begin
                tmr_clr = 1'b1;
                ras_clr = 1'b1;
                if (start_i) begin
                    d.st   = ST_FSTART;
                    d.mclk = 1'b0;
                    d.four = four_out_i;
                    d.ren  = reset_en_i;
                    d.glob = reset_global_i;
                    d.div  = half_div_i;
                    d.hold = reset_hold_i;
                end
            end
            ST_FSTART: begin
                if (tmr_hit) begin
                    tmr_clr = 1'b1;
                    d.st    = ST_PIXEL;
                end
            end
            ST_PIXEL: begin
                if (tmr_hit) begin
                    tmr_clr = 1'b1;
                    d.mclk  = ~q.mclk;
                    if (!at_last_col)     ras_step = 1'b1;
                    else if (line_rst)    d.st = ST_RESET;
                    else if (!at_last_row) ras_step = 1'b1;
                    else if (glob_rst)    d.st = ST_RESET;
                    else                  d.st = ST_DONE;
                end
            end
            ST_RESET: begin
                if (tmr_hit) begin
                    tmr_clr = 1'b1;
                    if (at_last_row) begin
                        d.st = ST_DONE;
                    end else begin
                        ras_step = 1'b1;
                        d.st     = ST_PIXEL;
                    end
                end
            end
            ST_DONE: begin
                tmr_clr = 1'b1;
                d.st    = ST_IDLE;
            end
            default: begin
                tmr_clr = 1'b1;
                d.st    = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mclk_o        = q.mclk;
    assign frame_start_o = (q.st == ST_FSTART);
    assign pix_valid_o   = (q.st == ST_PIXEL) && tmr_zero;
    assign pix_col_o     = (q.st == ST_PIXEL) ? col : '0;
    assign row_idx_o     = (q.st == ST_PIXEL || q.st == ST_RESET) ? row : '0;
    assign ref_pix_o     = (q.st == ST_PIXEL) && ref_raw;
    assign row_reset_o   = (q.st == ST_RESET);
    assign frame_done_o  = (q.st == ST_DONE);
    assign busy_o        = (q.st != ST_IDLE);

    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_start_o, pix_valid_o, row_reset_o, frame_done_o})); // R1
    AST_FSTART_MCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |-> !mclk_o); // R2
    AST_MCLK_ONLY_AT_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mclk_o) |-> $past(q.st == ST_PIXEL)); // R3
    AST_MCLK_FROZEN_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        row_reset_o && $past(row_reset_o) |-> $stable(mclk_o)); // R6
    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |=> !frame_done_o && !busy_o); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mclk_o && !pix_valid_o && !row_reset_o && !ref_pix_o); // R10
    AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && $past(busy_o) && !frame_done_o |-> $stable(q.four) && $stable(q.div)); // R8

endmodule

// File: tb/tb_rdseq_top.sv
module tb_rdseq_top;

    localparam int ROWS  = 4;
    localparam int COLS  = 32;
    localparam int COL_W = 3;
    localparam int ROW_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             four_out_i = 1'b0;
    logic             reset_en_i = 1'b0;
    logic             reset_global_i = 1'b0;
    logic [7:0]       half_div_i = '0;
    logic [11:0]      reset_hold_i = '0;
    logic             mclk_o, frame_start_o, pix_valid_o, ref_pix_o;
    logic             row_reset_o, frame_done_o, busy_o;
    logic [COL_W-1:0] pix_col_o;
    logic [ROW_W-1:0] row_idx_o;

    always #4 clk = ~clk;

    rdseq_top #(.ARR_ROWS(ROWS), .ARR_COLS(COLS)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .four_out_i(four_out_i),
        .reset_en_i(reset_en_i), .reset_global_i(reset_global_i),
        .half_div_i(half_div_i), .reset_hold_i(reset_hold_i),
        .mclk_o(mclk_o), .frame_start_o(frame_start_o), .pix_valid_o(pix_valid_o),
        .pix_col_o(pix_col_o), .row_idx_o(row_idx_o), .ref_pix_o(ref_pix_o),
        .row_reset_o(row_reset_o), .frame_done_o(frame_done_o), .busy_o(busy_o)
    );

    typedef struct packed {
        logic             mclk, fs, pv;
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
        logic             rf, rr, dn, bz;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   chk_on = 1'b0;

    function automatic exp_t blank();
        exp_t e;
        e = '0;
        return e;
    endfunction

    // Behavioural reference: append the whole expected trace of one frame.
    task automatic queue_frame(input bit four, input bit ren, input bit glob,
                               input int div, input int hold);
        int   len;
        int   hp;
        exp_t e;
        hp  = div + 1;
        len = four ? COLS / 4 : COLS / 16 + 6;
        for (int k = 0; k < hp; k++) begin
            e = blank(); e.fs = 1'b1; e.bz = 1'b1;
            exp_q.push_back(e);                          // R2
        end
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < len; c++) begin
                for (int k = 0; k < hp; k++) begin
                    e = blank(); e.bz = 1'b1;
                    e.mclk = (c % 2 == 1);               // R3
                    e.pv   = (k == 0);                   // R1
                    e.col  = COL_W'(c);
                    e.row  = ROW_W'(r);
                    e.rf   = (r == 0) || (r == ROWS - 1) ||
                             (!four && (c < 2 || c >= len - 4)); // R4 R5
                    exp_q.push_back(e);
                end
            end
            if (ren && !glob) begin
                for (int k = 0; k < 2 * hp + hold; k++) begin
                    e = blank(); e.bz = 1'b1; e.rr = 1'b1; e.row = ROW_W'(r);
                    exp_q.push_back(e);                  // R6
                end
            end
        end
        if (ren && glob) begin
            for (int k = 0; k < 2 * hp + hold; k++) begin
                e = blank(); e.bz = 1'b1; e.rr = 1'b1; e.row = ROW_W'(ROWS - 1);
                exp_q.push_back(e);                      // R7
            end
        end
        e = blank(); e.bz = 1'b1; e.dn = 1'b1;
        exp_q.push_back(e);                              // R9
    endtask

    task automatic field(input string tag, input string nm, input int act, input int ex,
                         inout bit bad);
        if (act != ex) begin
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, nm, act, ex, $time);
            bad = 1'b1;
        end
    endtask

    task automatic compare(input exp_t e);
        bit bad;
        bad = 1'b0;
        checks++;
        field("R3",  "mclk",        int'(mclk_o),        int'(e.mclk), bad);
        field("R2",  "frame_start", int'(frame_start_o), int'(e.fs),   bad);
        field("R1",  "pix_valid",   int'(pix_valid_o),   int'(e.pv),   bad);
        field("R1",  "pix_col",     int'(pix_col_o),     int'(e.col),  bad);
        field("R1",  "row_idx",     int'(row_idx_o),     int'(e.row),  bad);
        field("R4",  "ref_pix",     int'(ref_pix_o),     int'(e.rf),   bad);
        field("R6",  "row_reset",   int'(row_reset_o),   int'(e.rr),   bad);
        field("R9",  "frame_done",  int'(frame_done_o),  int'(e.dn),   bad);
        field("R10", "busy",        int'(busy_o),        int'(e.bz),   bad);
        if (bad) errors++;
    endtask

    always @(posedge clk) begin
        #2;
        if (chk_on) begin
            if (exp_q.size() > 0) compare(exp_q.pop_front());
            else                  compare(blank());
        end
    end

    task automatic launch(input bit four, input bit ren, input bit glob,
                          input int div, input int hold);
        @(negedge clk);
        four_out_i     = four;
        reset_en_i     = ren;
        reset_global_i = glob;
        half_div_i     = 8'(div);
        reset_hold_i   = 12'(hold);
        start_i        = 1'b1;
        queue_frame(four, ren, glob, div, hold);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        while (exp_q.size() > 0 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (exp_q.size() > 0) begin
            checks++; errors++;
            $display("FAIL R9 frame did not finish actual=%0d expected=0 left", exp_q.size());
            exp_q.delete();
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        compare(blank());
        start_i = 1'b1;                 // ignored while in reset
        @(negedge clk);
        compare(blank());
        start_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk_on = 1'b1;

        // 16-output mode, line-by-line reset (R1 R3 R4 R5 R6)
        launch(1'b0, 1'b1, 1'b0, 1, 3);
        wait_idle();
        // 4-output mode, global reset, fastest divider (R7)
        launch(1'b1, 1'b1, 1'b1, 0, 0);
        wait_idle();
        // 16-output mode, resets disabled (R7)
        launch(1'b0, 1'b0, 1'b1, 2, 7);
        wait_idle();
        // 4-output mode, line reset with long hold; mid-frame disturbance (R8)
        launch(1'b1, 1'b1, 1'b0, 1, 5);
        repeat (20) @(negedge clk);
        start_i = 1'b1; four_out_i = 1'b0; reset_en_i = 1'b0;
        half_div_i = 8'd4; reset_hold_i = 12'd0;
        @(negedge clk);
        start_i = 1'b0;
        repeat (30) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_idle();
        // 16-output mode, global reset, zero hold (R6 R7)
        launch(1'b0, 1'b1, 1'b1, 0, 0);
        wait_idle();

        chk_on = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule